// File: doc/BRIEF.md
# Latched Parity Bus Transceiver

This block joins two 9-bit buses, side A and side B. Each bus carries 8 data bits and 1 parity bit. Two active-low drive requests choose the direction of transfer. The side whose request is low receives data that comes from the latch on the other side. Each side has its own latch stage, which follows its bus while its latch enable is high and keeps its last contents while the enable is low.

On the way across, the parity bit is either passed through unchanged (feed-through) or replaced by a parity bit computed from the data (generate). A single select chooses odd or even parity. That select controls both the generated bit and the checking. Both sides are checked at the same time, and each side reports a mismatch on its own active-low error flag. A side that the block is driving loads its own driven word into its latch when its enable is high, so that side's flag checks the value that actually went out.

The physical buses are split into separate input, output and drive-enable signals. Tri-state pads sit outside the block. Every latch stage is a clock-enabled register, and every output is registered.

Top module: `lat_par_xcvr`

## Requirements
- R1: When exactly one of `en_a_n`/`en_b_n` is low, only that side's drive output (`a_drv` or `b_drv`) is high. When both are high, neither drive output is high.
- R2: When `en_a_n` and `en_b_n` are both low, neither `a_drv` nor `b_drv` is high.
- R3: With `feed_thru` = 0, the driven side carries the other side's latched data, and its parity bit is generated from that data.
- R4: With `feed_thru` = 1, the driven side carries the other side's latched data and latched parity bit unchanged.
- R5: With `odd_sel` = 1, the generated bit is the inverted XOR of the 8 data bits, so the 9-bit word has an odd number of ones. With `odd_sel` = 0, it is the XOR of the 8 data bits, so the word has an even number of ones. The same rule is used for checking.
- R6: Each error flag is low exactly when the parity generated from that side's latched data differs from that side's latched parity bit. Both flags are evaluated every cycle, in either parity mode.
- R7: While a side's latch enable is low, that side's latch keeps its contents. Changes on that side's bus inputs then have no effect on its error flag or on the word driven to the opposite side.
- R8: When a side is driven and its latch enable is high, that side's latch loads the driven word. In generate mode, this keeps that side's error flag high.
- R9: Synchronous active-high `rst` clears both latches and all output registers. After reset, both drive outputs are low and, with `odd_sel` = 0, both error flags are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en_a_n | input | 1 | Request to drive side A, active low |
| en_b_n | input | 1 | Request to drive side B, active low |
| feed_thru | input | 1 | 1: pass parity through; 0: generate parity |
| odd_sel | input | 1 | 1: odd parity; 0: even parity |
| le_a | input | 1 | Side A latch enable, high = follow bus |
| le_b | input | 1 | Side B latch enable, high = follow bus |
| a_dat_i | input | 8 | Side A bus data seen by the block |
| a_par_i | input | 1 | Side A bus parity seen by the block |
| b_dat_i | input | 8 | Side B bus data seen by the block |
| b_par_i | input | 1 | Side B bus parity seen by the block |
| a_dat_o | output | 8 | Data driven toward side A |
| a_par_o | output | 1 | Parity driven toward side A |
| a_drv | output | 1 | Side A driver enable |
| b_dat_o | output | 8 | Data driven toward side B |
| b_par_o | output | 1 | Parity driven toward side B |
| b_drv | output | 1 | Side B driver enable |
| err_a_n | output | 1 | Side A parity error, active low |
| err_b_n | output | 1 | Side B parity error, active low |

## Verification
Timing is counted in clock edges after a stimulus. The drive enables follow the requests after 1 edge. A receiving latch captures its bus after 1 edge, and the driven word and that side's error flag appear after 2 edges. A looped-back latch captures the driven word on the same edge as the output register, so the driven side's error flag settles after 3 edges. The driver task holds each stimulus for 4 edges before it pushes the expected word, and the monitor compares one half period later, after every result has settled. Hold cases are built in two steps: first a value is captured, then the enable is dropped and the bus inputs are changed. The expected results for the second step still use the captured value.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
  typedef enum logic [1:0] {
    DIR_IDLE = 2'd0,
    DIR_TO_A = 2'd1,
    DIR_TO_B = 2'd2
  } dir_e;
endpackage

// File: rtl/lpt_dir_ctrl.sv
module lpt_dir_ctrl (
  input  logic          en_a_n,
  input  logic          en_b_n,
  output lpt_pkg::dir_e dir
);
  // Both requests low is illegal: fall back to idle so the buses never fight.
  always_comb begin
    unique case ({en_a_n, en_b_n})
      2'b01:   dir = lpt_pkg::DIR_TO_A;
      2'b10:   dir = lpt_pkg::DIR_TO_B;
      default: dir = lpt_pkg::DIR_IDLE;
    endcase
  end
endmodule

// File: rtl/lpt_xfer.sv
module lpt_xfer #(
  parameter int unsigned DW = 8
) (
  input  logic [DW-1:0] src_dat,
  input  logic          src_par,
  input  logic          feed,
  input  logic          odd,
  output logic [DW-1:0] dst_dat,
  output logic          dst_par
);
  logic gen_par;
  assign gen_par = odd ? ~(^src_dat) : (^src_dat);
  assign dst_dat = src_dat;
  assign dst_par = feed ? src_par : gen_par;
endmodule

// File: rtl/lpt_latch.sv
module lpt_latch #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          le,
  input  logic          use_loop,
  input  logic [DW-1:0] bus_dat,
  input  logic          bus_par,
  input  logic [DW-1:0] loop_dat,
  input  logic          loop_par,
  output logic [DW-1:0] q_dat,
  output logic          q_par
);
  // Clock-enabled register standing in for a transparent latch.
  always_ff @(posedge clk) begin
    if (rst) begin
      q_dat <= '0;
      q_par <= 1'b0;
    end else if (le) begin
      q_dat <= use_loop ? loop_dat : bus_dat;
      q_par <= use_loop ? loop_par : bus_par;
    end
  end
endmodule

// File: rtl/lpt_check.sv
module lpt_check #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] dat,
  input  logic          par,
  input  logic          odd,
  output logic          err_n
);
  logic exp_par;
  assign exp_par = odd ? ~(^dat) : (^dat);

  always_ff @(posedge clk) begin
    if (rst) err_n <= 1'b1;
    else     err_n <= (exp_par == par);
  end
endmodule

// File: rtl/lat_par_xcvr.sv
module lat_par_xcvr #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en_a_n,
  input  logic          en_b_n,
  input  logic          feed_thru,
  input  logic          odd_sel,
  input  logic          le_a,
  input  logic          le_b,
  input  logic [DW-1:0] a_dat_i,
  input  logic          a_par_i,
  input  logic [DW-1:0] b_dat_i,
  input  logic          b_par_i,
  output logic [DW-1:0] a_dat_o,
  output logic          a_par_o,
  output logic          a_drv,
  output logic [DW-1:0] b_dat_o,
  output logic          b_par_o,
  output logic          b_drv,
  output logic          err_a_n,
  output logic          err_b_n
);
  localparam int unsigned NSIDE = 2;  // index 0 = side A, 1 = side B

  lpt_pkg::dir_e dir;

  logic [NSIDE-1:0][DW-1:0] in_dat, lat_dat, nxt_dat;
  logic [NSIDE-1:0]         in_par, lat_par, nxt_par;
  logic [NSIDE-1:0]         le_v, drv_v, err_v;

  assign in_dat = {b_dat_i, a_dat_i};
  assign in_par = {b_par_i, a_par_i};
  assign le_v   = {le_b, le_a};
  assign drv_v  = {(dir == lpt_pkg::DIR_TO_B), (dir == lpt_pkg::DIR_TO_A)};

  lpt_dir_ctrl u_dir (
    .en_a_n (en_a_n),
    .en_b_n (en_b_n),
    .dir    (dir)
  );

  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    // Word headed for side s comes from the opposite latch.
    lpt_xfer #(.DW(DW)) u_xfer (
      .src_dat (lat_dat[NSIDE-1-s]),
      .src_par (lat_par[NSIDE-1-s]),
      .feed    (feed_thru),
      .odd     (odd_sel),
      .dst_dat (nxt_dat[s]),
      .dst_par (nxt_par[s])
    );

    lpt_latch #(.DW(DW)) u_latch (
      .clk      (clk),
      .rst      (rst),
      .le       (le_v[s]),
      .use_loop (drv_v[s]),
      .bus_dat  (in_dat[s]),
      .bus_par  (in_par[s]),
      .loop_dat (nxt_dat[s]),
      .loop_par (nxt_par[s]),
      .q_dat    (lat_dat[s]),
      .q_par    (lat_par[s])
    );

    lpt_check #(.DW(DW)) u_check (
      .clk   (clk),
      .rst   (rst),
      .dat   (lat_dat[s]),
      .par   (lat_par[s]),
      .odd   (odd_sel),
      .err_n (err_v[s])
    );
  end

  assign err_a_n = err_v[0];
  assign err_b_n = err_v[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      a_dat_o <= '0;
      a_par_o <= 1'b0;
      a_drv   <= 1'b0;
      b_dat_o <= '0;
      b_par_o <= 1'b0;
      b_drv   <= 1'b0;
    end else begin
      a_dat_o <= nxt_dat[0];
      a_par_o <= nxt_par[0];
      a_drv   <= drv_v[0];
      b_dat_o <= nxt_dat[1];
      b_par_o <= nxt_par[1];
      b_drv   <= drv_v[1];
    end
  end

  AST_ONE_SIDE_B: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(!en_b_n && en_a_n)) |-> (b_drv && !a_drv)); // R1

  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(!en_a_n && !en_b_n)) |-> (!a_drv && !b_drv)); // R2

  AST_GEN_PARITY_B: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(!feed_thru)) |->
      (b_par_o == ($past(odd_sel) ? ~(^b_dat_o) : (^b_dat_o)))); // R3

  AST_HOLD_ERR_A: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && $past(!le_a, 2) &&
     ($past(odd_sel) == $past(odd_sel, 2))) |-> $stable(err_a_n)); // R7

  AST_LOOP_CHECK_B: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) &&
     $past(!en_b_n && en_a_n && le_b && !feed_thru, 2) &&
     ($past(odd_sel) == $past(odd_sel, 2))) |-> err_b_n); // R8
endmodule

// File: tb/test_lat_par_xcvr.sv
module test_lat_par_xcvr;
  localparam int DW = 8;

  typedef struct {
    string      tag;
    logic       a_drv, b_drv, err_a, err_b;
    logic [8:0] a_word, b_word;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en_a_n = 1'b1, en_b_n = 1'b1, feed_thru = 1'b0, odd_sel = 1'b0;
  logic le_a = 1'b0, le_b = 1'b0;
  logic [DW-1:0] a_dat_i = '0, b_dat_i = '0;
  logic a_par_i = 1'b0, b_par_i = 1'b0;
  logic [DW-1:0] a_dat_o, b_dat_o;
  logic a_par_o, b_par_o, a_drv, b_drv, err_a_n, err_b_n;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  exp_t sbq[$];
  logic [8:0] held_a = '0, held_b = '0;  // {parity, data}

  always #2.5 clk = ~clk;

  lat_par_xcvr #(.DW(DW)) i_lat_par_xcvr (
    .clk(clk), .rst(rst), .en_a_n(en_a_n), .en_b_n(en_b_n),
    .feed_thru(feed_thru), .odd_sel(odd_sel), .le_a(le_a), .le_b(le_b),
    .a_dat_i(a_dat_i), .a_par_i(a_par_i), .b_dat_i(b_dat_i), .b_par_i(b_par_i),
    .a_dat_o(a_dat_o), .a_par_o(a_par_o), .a_drv(a_drv),
    .b_dat_o(b_dat_o), .b_par_o(b_par_o), .b_drv(b_drv),
    .err_a_n(err_a_n), .err_b_n(err_b_n)
  );

  function automatic logic ref_par(input logic [7:0] d, input logic odd);
    int ones = 0;
    for (int i = 0; i < 8; i++) ones += int'(d[i]);
    // R5: the generated bit makes the total count of ones odd or even.
    return odd ? ((ones % 2) == 0) : ((ones % 2) == 1);
  endfunction

  function automatic logic [8:0] ref_xfer(input logic [8:0] w, input logic ft, input logic odd);
    return {ft ? w[8] : ref_par(w[7:0], odd), w[7:0]};
  endfunction

  task automatic cmp(input string tag, input string what, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic apply(input string tag, input logic oa, input logic ob, input logic ft,
                       input logic odd, input logic la, input logic lb,
                       input logic [7:0] ad, input logic ap, input logic [7:0] bd, input logic bp);
    logic drva, drvb;
    logic [8:0] wa, wb, ao, bo;
    exp_t e;
    @(negedge clk);
    en_a_n = oa; en_b_n = ob; feed_thru = ft; odd_sel = odd;
    le_a = la; le_b = lb; a_dat_i = ad; a_par_i = ap; b_dat_i = bd; b_par_i = bp;
    drva = !oa && ob;
    drvb = !ob && oa;
    wa = la ? {ap, ad} : held_a;
    wb = lb ? {bp, bd} : held_b;
    ao = '0; bo = '0;
    if (drvb) begin
      bo = ref_xfer(wa, ft, odd);
      wb = lb ? bo : held_b;
    end
    if (drva) begin
      ao = ref_xfer(wb, ft, odd);
      wa = la ? ao : held_a;
    end
    held_a = wa;
    held_b = wb;
    e.tag = tag; e.a_drv = drva; e.b_drv = drvb;
    e.err_a = (ref_par(wa[7:0], odd) == wa[8]);
    e.err_b = (ref_par(wb[7:0], odd) == wb[8]);
    e.a_word = ao; e.b_word = bo;
    repeat (4) @(posedge clk);
    #1 sbq.push_back(e);
  endtask

  // Monitor: compares queued expectations half a period after the edge.
  initial begin
    forever begin
      @(negedge clk);
      while (sbq.size() > 0) begin
        exp_t e;
        e = sbq.pop_front();
        cmp(e.tag, "a_drv", {8'h0, a_drv}, {8'h0, e.a_drv});
        cmp(e.tag, "b_drv", {8'h0, b_drv}, {8'h0, e.b_drv});
        cmp(e.tag, "err_a_n", {8'h0, err_a_n}, {8'h0, e.err_a});
        cmp(e.tag, "err_b_n", {8'h0, err_b_n}, {8'h0, e.err_b});
        if (e.a_drv) cmp(e.tag, "a_word", {a_par_o, a_dat_o}, e.a_word);
        if (e.b_drv) cmp(e.tag, "b_word", {b_par_o, b_dat_o}, e.b_word);
      end
    end
  end

  initial begin
    #(100000 * 5);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    exp_t r;
    repeat (5) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    // R9: first edge after reset, all registers cleared, even parity on zero words.
    @(posedge clk);
    #1;
    r.tag = "R9 reset"; r.a_drv = 0; r.b_drv = 0; r.err_a = 1; r.err_b = 1;
    r.a_word = '0; r.b_word = '0;
    sbq.push_back(r);
    // R3 R6 R8: A to B generate, even, bad A parity flagged, B loopback clean.
    apply("R3 R6 R8 gen even", 1, 0, 0, 0, 1, 1, 8'h5A, 1, 8'h00, 0);
    // R4 R8: feed-through odd, bad parity travels and both flags drop.
    apply("R4 R8 feed odd", 1, 0, 1, 1, 1, 1, 8'h01, 1, 8'h33, 0);
    // R3 R5: B to A generate odd.
    apply("R3 R5 gen odd to A", 0, 1, 0, 1, 1, 1, 8'h00, 0, 8'hFF, 1);
    apply("R5 gen even to A", 0, 1, 0, 0, 1, 1, 8'h00, 0, 8'h07, 0);
    // R7: capture on B, then drop le_b and change B inputs.
    apply("R7 capture", 0, 1, 0, 0, 1, 1, 8'h00, 0, 8'h0F, 0);
    apply("R7 hold B", 0, 1, 0, 0, 1, 0, 8'h00, 0, 8'hF1, 0);
    apply("R7 hold B feed", 0, 1, 1, 0, 1, 0, 8'h00, 0, 8'h80, 1);
    // R8: driven side A with its latch closed: flag follows held word.
    apply("R8 A closed", 0, 1, 1, 0, 0, 1, 8'h00, 0, 8'h03, 1);
    // R6: both sides receive, no drive, both checked at once.
    apply("R1 R6 idle", 1, 1, 0, 0, 1, 1, 8'h11, 1, 8'h12, 0);
    apply("R6 idle odd", 1, 1, 0, 1, 1, 1, 8'h11, 1, 8'h12, 0);
    // R2: illegal both-low request.
    apply("R2 both low", 0, 0, 0, 0, 1, 1, 8'hC3, 0, 8'h3C, 1);
    // R7: side A closed while receiving; its flag ignores bus changes.
    apply("R7 hold A", 1, 1, 0, 0, 0, 1, 8'h01, 0, 8'h12, 1);
    apply("R1 R4 feed to B", 1, 0, 1, 0, 1, 1, 8'hAA, 1, 8'h00, 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule